// File: doc/BRIEF.md
# SDRAM Power-Down Sequencer

This block sits between the command scheduler of an SDRAM controller and the memory pins. When the scheduler signals that it has nothing to do, the block takes over the command bus and puts the device into low-power standby by dropping the clock-enable line. Later it raises the line again and hands the bus back. While it holds the bus it drives NOP on every cycle except one: the close-all-banks PRECHARGE, which it drives itself.

Two standby flavours are supported. On the precharged path the block first closes every open row with PRECHARGE (A10 high). It then waits out the row-precharge time and holds off until the bank status shows all banks idle. On the row-open path it enters standby straight away, and any open rows stay open. The flavour is reported for the whole time CKE is low. No refresh can be issued during standby. For that reason a refresh-due indication forces an exit. A residence counter also bounds the stay: when the counter runs out it forces an exit and raises a sticky error flag. The cause of the last exit is reported on a two-bit status output.

Top module: `sdram_pd_seq`

## Requirements
- R1: After reset cke_o is 1, sched_gnt_o is 1, pd_mode_o is 00, exit_cause_o is 00 and res_err_o is 0.
- R2: While the block is idle, sched_gnt_o is 1, and cmd_o, a10_o and ba_o equal sched_cmd_i, sched_a10_i and sched_ba_i. The command codes are 00 NOP, 01 PRECHARGE, 10 ACTIVE and 11 other.
- R3: A standby request in sleep_req_i is accepted only while idle, and only in a cycle where access_busy_i and refresh_due_i are both low. While a request is refused, cke_o stays 1 and sched_gnt_o stays 1.
- R4: A request with pre_path_i=1 while any bit of bank_open_i is set gives one cycle of cmd_o=01 with a10_o=1 and ba_o=0. NOP cycles with CKE high follow, for at least TRP_CYC cycles and until bank_open_i is all zero. Only then does cke_o go low.
- R5: While cke_o is low, pd_mode_o is 01 (precharged) if bank_open_i was all zero when entry was decided, and 10 (row open) otherwise. It is 00 whenever cke_o is 1.
- R6: While cke_o is low, cmd_o is NOP, a10_o and ba_o are 0, and sched_gnt_o is 0. sleep_req_i and the scheduler bus inputs have no effect. cke_o stays low for at least two cycles.
- R7: After at least one cycle of standby, a high wake_i or refresh_due_i raises cke_o on the next cycle. cmd_o then stays NOP with sched_gnt_o at 0 for EXIT_NOPS cycles, after which the bus returns to the scheduler.
- R8: exit_cause_o reads 00 from the first low CKE cycle. On exit it is set to 11 for the residence limit, 10 for refresh due and 01 for wake, with priority in that order, and it holds until the next entry.
- R9: cke_o is never low for more than RES_LIMIT consecutive cycles. Reaching the limit forces an exit with cause 11 and sets res_err_o, which stays 1 until reset.
- R10: A refresh_due_i that arrives while waiting for the precharge to complete abandons entry. The block returns to idle on the next cycle, with the bus given back and CKE still high.
- R11: A sleep_req_i held high through an exit is acted on only after one idle cycle with sched_gnt_o at 1. CKE then goes low on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sleep_req_i | input | 1 | Scheduler idle, standby requested |
| pre_path_i | input | 1 | 1 = close all banks before standby |
| bank_open_i | input | NUM_BANKS | Per-bank open-row status |
| access_busy_i | input | 1 | Read or write still in flight |
| refresh_due_i | input | 1 | Refresh timer requests a refresh |
| wake_i | input | 1 | Scheduler wants the bus back |
| sched_cmd_i | input | 2 | Scheduler command |
| sched_a10_i | input | 1 | Scheduler A10 bit |
| sched_ba_i | input | BA_W | Scheduler bank address |
| cke_o | output | 1 | Clock enable to the device |
| cmd_o | output | 2 | Command to the device |
| a10_o | output | 1 | A10 bit to the device |
| ba_o | output | BA_W | Bank address to the device |
| sched_gnt_o | output | 1 | Scheduler owns the command bus |
| pd_mode_o | output | 2 | Standby flavour: 00 none, 01 precharged, 10 row open |
| exit_cause_o | output | 2 | Last exit cause: 01 wake, 10 refresh, 11 limit |
| res_err_o | output | 1 | Sticky residence-limit error |

## Verification
The entry and exit sequence is swept over every bank-open pattern of a four-bank configuration, with both path selections and three exit stimuli (wake alone, refresh alone, both together). Each run is timed against a cycle count worked out in the bench. The sweep separates the precharged path from the row-open path, and the immediate-close case from the case where banks close late. It also shows that refresh takes priority over wake in the cause code. Separate runs hold the request against a busy access and against a pending refresh to show that entry is refused. Other runs let the residence counter expire, abandon a precharge on refresh, and keep the request asserted through an exit to expose re-entry timing.

// File: rtl/sdram_pd_pkg.sv
package sdram_pd_pkg;
  typedef enum logic [1:0] {
    CMD_NOP = 2'd0, CMD_PRE = 2'd1, CMD_ACT = 2'd2, CMD_OTH = 2'd3
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE_ALL, ST_WAIT_TRP, ST_ENTER_PD, ST_IN_PD, ST_EXIT_PD
  } pd_st_e;

  localparam logic [1:0] PDM_NONE = 2'd0;
  localparam logic [1:0] PDM_PRE  = 2'd1;
  localparam logic [1:0] PDM_ACT  = 2'd2;

  localparam logic [1:0] CAUSE_NONE  = 2'd0;
  localparam logic [1:0] CAUSE_WAKE  = 2'd1;
  localparam logic [1:0] CAUSE_REF   = 2'd2;
  localparam logic [1:0] CAUSE_LIMIT = 2'd3;
endpackage

// File: rtl/pd_cnt.sv
module pd_cnt #(
  parameter int W   = 4,
  parameter int MAX = 15
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MaxV = W'(MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_o <= '0;
    else if (clr_i)                    cnt_o <= '0;
    else if (en_i && cnt_o != MaxV)    cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/pd_fsm.sv
module pd_fsm
  import sdram_pd_pkg::*;
#(
  parameter int TRP_CYC   = 2,
  parameter int EXIT_NOPS = 2,
  parameter int RES_LIMIT = 1024,
  parameter int PH_W      = 2,
  parameter int RES_W     = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sleep_req_i,
  input  logic             pre_path_i,
  input  logic             any_open_i,
  input  logic             access_busy_i,
  input  logic             refresh_due_i,
  input  logic             wake_i,
  input  logic [PH_W-1:0]  ph_cnt_i,
  input  logic [RES_W-1:0] res_cnt_i,
  output pd_st_e           st_o,
  output logic             st_chg_o,
  output logic [1:0]       flav_o,
  output logic [1:0]       cause_o,
  output logic             err_o
);
  localparam logic [PH_W-1:0]  TrpLast  = PH_W'(TRP_CYC - 1);
  localparam logic [PH_W-1:0]  ExitLast = PH_W'(EXIT_NOPS - 1);
  localparam logic [RES_W-1:0] ResLast  = RES_W'(RES_LIMIT - 1);

  pd_st_e st_q, st_d;
  logic   limit_hit;

  assign limit_hit = (st_q == ST_IN_PD) && (res_cnt_i == ResLast);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:
        if (sleep_req_i && !access_busy_i && !refresh_due_i)
          st_d = (pre_path_i && any_open_i) ? ST_PRE_ALL : ST_ENTER_PD;
      ST_PRE_ALL:  st_d = ST_WAIT_TRP;
      ST_WAIT_TRP:
        if (refresh_due_i)
          st_d = ST_IDLE;
        else if (!any_open_i && !access_busy_i && ph_cnt_i >= TrpLast)
          st_d = ST_ENTER_PD;
      ST_ENTER_PD: st_d = ST_IN_PD;
      ST_IN_PD:
        if (limit_hit || refresh_due_i || wake_i) st_d = ST_EXIT_PD;
      ST_EXIT_PD:
        if (ph_cnt_i == ExitLast) st_d = ST_IDLE;
      default:     st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      flav_o  <= PDM_NONE;
      cause_o <= CAUSE_NONE;
      err_o   <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_d == ST_ENTER_PD && st_q != ST_ENTER_PD) begin
        flav_o  <= any_open_i ? PDM_ACT : PDM_PRE;
        cause_o <= CAUSE_NONE;
      end
      if (st_q == ST_IN_PD && st_d == ST_EXIT_PD)
        cause_o <= limit_hit ? CAUSE_LIMIT : (refresh_due_i ? CAUSE_REF : CAUSE_WAKE);
      if (limit_hit) err_o <= 1'b1;
    end
  end

  assign st_o     = st_q;
  assign st_chg_o = (st_d != st_q);
endmodule

// File: rtl/sdram_pd_seq.sv
module sdram_pd_seq
  import sdram_pd_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BA_W      = $clog2(NUM_BANKS),
  parameter int TRP_CYC   = 2,
  parameter int EXIT_NOPS = 2,
  parameter int RES_LIMIT = 1024
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sleep_req_i,
  input  logic                 pre_path_i,
  input  logic [NUM_BANKS-1:0] bank_open_i,
  input  logic                 access_busy_i,
  input  logic                 refresh_due_i,
  input  logic                 wake_i,
  input  logic [1:0]           sched_cmd_i,
  input  logic                 sched_a10_i,
  input  logic [BA_W-1:0]      sched_ba_i,
  output logic                 cke_o,
  output logic [1:0]           cmd_o,
  output logic                 a10_o,
  output logic [BA_W-1:0]      ba_o,
  output logic                 sched_gnt_o,
  output logic [1:0]           pd_mode_o,
  output logic [1:0]           exit_cause_o,
  output logic                 res_err_o
);
  localparam int PH_MAX = (TRP_CYC > EXIT_NOPS) ? TRP_CYC : EXIT_NOPS;
  localparam int PH_W   = $clog2(PH_MAX + 1);
  localparam int RES_W  = $clog2(RES_LIMIT + 1);

  pd_st_e           st;
  logic             st_chg, cke_low;
  logic [PH_W-1:0]  ph_cnt;
  logic [RES_W-1:0] res_cnt;
  logic [1:0]       flav;

  // cycles spent in the current state
  pd_cnt #(.W(PH_W), .MAX(PH_MAX)) u_ph_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(st_chg), .en_i(1'b1), .cnt_o(ph_cnt)
  );

  // cycles spent with CKE low
  pd_cnt #(.W(RES_W), .MAX(RES_LIMIT)) u_res_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(!cke_low), .en_i(cke_low), .cnt_o(res_cnt)
  );

  pd_fsm #(
    .TRP_CYC(TRP_CYC), .EXIT_NOPS(EXIT_NOPS), .RES_LIMIT(RES_LIMIT),
    .PH_W(PH_W), .RES_W(RES_W)
  ) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .sleep_req_i(sleep_req_i), .pre_path_i(pre_path_i),
    .any_open_i(|bank_open_i), .access_busy_i(access_busy_i),
    .refresh_due_i(refresh_due_i), .wake_i(wake_i),
    .ph_cnt_i(ph_cnt), .res_cnt_i(res_cnt),
    .st_o(st), .st_chg_o(st_chg), .flav_o(flav),
    .cause_o(exit_cause_o), .err_o(res_err_o)
  );

  assign cke_low     = (st == ST_ENTER_PD) || (st == ST_IN_PD);
  assign cke_o       = !cke_low;
  assign sched_gnt_o = (st == ST_IDLE);
  assign pd_mode_o   = cke_low ? flav : PDM_NONE;

  always_comb begin
    cmd_o = CMD_NOP;
    a10_o = 1'b0;
    ba_o  = '0;
    if (st == ST_IDLE) begin
      cmd_o = sched_cmd_i;
      a10_o = sched_a10_i;
      ba_o  = sched_ba_i;
    end else if (st == ST_PRE_ALL) begin
      cmd_o = CMD_PRE;
      a10_o = 1'b1;
    end
  end
endmodule

// File: rtl/sdram_pd_chk.sv
module sdram_pd_chk
  import sdram_pd_pkg::*;
#(
  parameter int BA_W      = 2,
  parameter int RES_LIMIT = 1024
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            access_busy_i,
  input logic            refresh_due_i,
  input logic            cke_o,
  input logic [1:0]      cmd_o,
  input logic            a10_o,
  input logic [BA_W-1:0] ba_o,
  input logic            sched_gnt_o,
  input logic [1:0]      pd_mode_o,
  input logic [1:0]      exit_cause_o,
  input logic            res_err_o
);
  int unsigned low_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     low_cnt <= 0;
    else if (!cke_o) low_cnt <= low_cnt + 1;
    else             low_cnt <= 0;
  end

  assert_entry_gate_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cke_o) |-> (!$past(access_busy_i) && !$past(refresh_due_i)));

  assert_pre_a10_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_PRE && !sched_gnt_o) |-> (a10_o && ba_o == '0 && cke_o));

  assert_pre_then_nop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_PRE && !sched_gnt_o) |=> (cmd_o == CMD_NOP && cke_o));

  assert_mode_flag_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_o ? (pd_mode_o == PDM_NONE) : (pd_mode_o == PDM_PRE || pd_mode_o == PDM_ACT));

  assert_low_nop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cke_o |-> (cmd_o == CMD_NOP && !sched_gnt_o && !a10_o));

  assert_min_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cke_o) |=> !cke_o);

  assert_exit_nop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cke_o) |-> (cmd_o == CMD_NOP && !sched_gnt_o));

  assert_cause_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cke_o) |-> (exit_cause_o != CAUSE_NONE));

  assert_cause_clr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cke_o) |-> (exit_cause_o == CAUSE_NONE));

  assert_residence_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cke_o |-> (low_cnt < RES_LIMIT));

  assert_err_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(res_err_o) |-> res_err_o);
endmodule

bind sdram_pd_seq sdram_pd_chk #(.BA_W(BA_W), .RES_LIMIT(RES_LIMIT)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .access_busy_i(access_busy_i),
  .refresh_due_i(refresh_due_i), .cke_o(cke_o), .cmd_o(cmd_o), .a10_o(a10_o),
  .ba_o(ba_o), .sched_gnt_o(sched_gnt_o), .pd_mode_o(pd_mode_o),
  .exit_cause_o(exit_cause_o), .res_err_o(res_err_o)
);

// File: tb/sdram_pd_seq_tb.sv
module sdram_pd_seq_tb;
  localparam int NB = 4, BAW = 2, TRP = 2, EXN = 2, LIM = 12;

  logic clk = 0, rst_n = 0;
  logic sleep = 0, mpre = 0, busy = 0, refr = 0, wake = 0;
  logic [NB-1:0] bopen = '0;
  logic [1:0] scmd = 2'd0;
  logic sa10 = 0;
  logic [BAW-1:0] sba = '0;
  logic cke, a10, gnt, err;
  logic [1:0] cmd, pdm, cause;
  logic [BAW-1:0] ba;
  int nchk = 0, nerr = 0;

  always #4 clk = ~clk;

  sdram_pd_seq #(.NUM_BANKS(NB), .TRP_CYC(TRP), .EXIT_NOPS(EXN), .RES_LIMIT(LIM)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sleep_req_i(sleep), .pre_path_i(mpre),
    .bank_open_i(bopen), .access_busy_i(busy), .refresh_due_i(refr), .wake_i(wake),
    .sched_cmd_i(scmd), .sched_a10_i(sa10), .sched_ba_i(sba),
    .cke_o(cke), .cmd_o(cmd), .a10_o(a10), .ba_o(ba), .sched_gnt_o(gnt),
    .pd_mode_o(pdm), .exit_cause_o(cause), .res_err_o(err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic chk_low(input string req);
    chk({req, " cke"}, cke, 0);
    chk({req, " cmd"}, cmd, 0);
    chk({req, " a10/ba"}, {a10, ba}, 0);
    chk({req, " gnt"}, gnt, 0);
  endtask

  // csel: 0 refresh, 1 wake, 2 both; k = extra standby cycles before trigger
  task automatic run_pd(input int pre, input int open, input int csel, input int k);
    int expm, nwait;
    logic [1:0] expc;
    @(negedge clk); mpre = pre[0]; bopen = open[NB-1:0]; sleep = 1;
    scmd = 2'd2; sa10 = open[0]; sba = open[1:0]; #1;
    chk("R2 gnt", gnt, 1);
    chk("R2 pass", {cmd, a10, ba}, {2'd2, open[0], open[1:0]});
    if (pre != 0 && open != 0) begin
      @(negedge clk); sleep = 0; #1;
      chk("R4 pre", {cmd, a10, ba, cke, gnt}, {2'd1, 1'b1, 2'd0, 1'b1, 1'b0});
      nwait = open[0] ? 3 : TRP;
      if (!open[0]) bopen = '0;
      for (int i = 0; i < nwait; i++) begin
        @(negedge clk); if (i == nwait - 1) bopen = '0; #1;
        chk("R4 wait", {cke, cmd, gnt}, {1'b1, 2'd0, 1'b0});
      end
      expm = 1;
    end else expm = (open != 0) ? 2 : 1;
    @(negedge clk); sleep = 1; scmd = 2'd1; sa10 = 1; sba = 2'd3; #1;
    chk_low("R6 enter");
    chk("R5 mode", pdm, expm[1:0]);
    chk("R8 clr", cause, 0);
    for (int i = 0; i < k; i++) begin
      @(negedge clk); sleep = ~sleep; #1;
      chk_low("R6 hold");
      chk("R5 mode hold", pdm, expm[1:0]);
    end
    @(negedge clk); if (csel != 1) refr = 1; if (csel != 0) wake = 1; #1;
    chk("R7 trig cycle", cke, 0);
    expc = (csel == 1) ? 2'd1 : 2'd2;
    for (int i = 0; i < EXN; i++) begin
      @(negedge clk); if (i == 0) begin wake = 0; refr = 0; sleep = 0; end #1;
      chk("R7 exit", {cke, cmd, gnt}, {1'b1, 2'd0, 1'b0});
      chk("R8 cause", cause, expc);
      chk("R5 none", pdm, 0);
    end
    @(negedge clk); scmd = 2'd2; #1;
    chk("R7 back", {gnt, cke, cmd}, {1'b1, 1'b1, 2'd2});
  endtask

  initial begin
    #(8 * 200000);
    nerr++;
    $display("FAIL watchdog");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    #3;
    chk("R1 rst", {cke, gnt, pdm, cause, err}, {1'b1, 1'b1, 2'd0, 2'd0, 1'b0});
    @(negedge clk); @(negedge clk); rst_n = 1;
    @(negedge clk); #1;
    chk("R1 post", {cke, gnt, pdm, cause, err}, {1'b1, 1'b1, 2'd0, 2'd0, 1'b0});

    for (int p = 0; p < 2; p++)
      for (int o = 0; o < 16; o++)
        for (int c = 0; c < 3; c++)
          run_pd(p, o, c, o % 4);

    // R3: refused while busy, then while refresh due
    @(negedge clk); sleep = 1; busy = 1; mpre = 0; bopen = '0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); #1; chk("R3 busy", {cke, gnt}, 2'b11);
    end
    @(negedge clk); busy = 0; refr = 1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); #1; chk("R3 refresh", {cke, gnt}, 2'b11);
    end
    @(negedge clk); refr = 0; sleep = 0;

    // R10: refresh during precharge wait abandons entry
    @(negedge clk); sleep = 1; mpre = 1; bopen = 4'hf; #1;
    @(negedge clk); sleep = 0; #1; chk("R10 pre", cmd, 1);
    @(negedge clk); refr = 1; #1; chk("R10 wait", {cke, gnt}, 2'b10);
    @(negedge clk); #1; chk("R10 abort", {cke, gnt}, 2'b11);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1; chk("R10 stays", cke, 1);
    end
    @(negedge clk); refr = 0; bopen = '0; mpre = 0;

    // R9: residence limit
    chk("R9 err pre", err, 0);
    @(negedge clk); sleep = 1; #1;
    for (int i = 0; i < LIM; i++) begin
      @(negedge clk); sleep = 0; #1; chk("R9 low", cke, 0);
    end
    @(negedge clk); #1;
    chk("R9 exit", cke, 1);
    chk("R9 cause", cause, 3);
    chk("R9 err", err, 1);
    @(negedge clk); @(negedge clk); #1;
    chk("R9 back", gnt, 1);
    chk("R9 sticky", err, 1);

    // R11: request held through exit
    @(negedge clk); sleep = 1; #1;
    @(negedge clk); #1; chk("R11 low", cke, 0);
    @(negedge clk); wake = 1; #1;
    @(negedge clk); wake = 0; #1; chk("R11 exit", cke, 1);
    @(negedge clk); #1; chk("R11 exit2", {cke, gnt}, 2'b10);
    @(negedge clk); #1; chk("R11 idle", {cke, gnt}, 2'b11);
    @(negedge clk); sleep = 0; #1; chk("R11 reenter", cke, 0);
    @(negedge clk); wake = 1; #1;
    @(negedge clk); wake = 0;
    repeat (4) @(negedge clk);
    #1; chk("R11 done", gnt, 1);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule